// File: doc/BRIEF.md
# Coefficient RAM Block Transfer Engine

This block holds the per-channel filter coefficient memory of a multichannel codec and moves data into and out of it through a byte-framed command port. Each channel owns 40 coefficient words of 14 bits each, arranged as five blocks of eight words. A frame opens when `cs_n` falls. The first byte strobed in is a command that names a block and a direction. The engine then walks all eight words of that block by itself, starting at the highest word and counting down.

Each word crosses the port as a 16-bit value split into two bytes, high byte first. On a write, the two low bits of the 16-bit value are discarded. A word is committed only once its second byte arrives, and it lands in every channel whose bit is set in `ch_enable`, which is sampled when the command byte is accepted. On a read, the word comes from the lowest-numbered enabled channel and leaves with its two spare low bits forced to zero. Raising `cs_n` abandons the frame at once. Words already completed stay written.

The controller has six named states.
- `ST_IDLE` waits for a command byte.
- `ST_WR_HI` and `ST_WR_LO` take the high and low byte of a write word.
- `ST_RD_HI` and `ST_RD_LO` emit the high and low byte of a read word.
- `ST_DONE` swallows any bytes after the block, or after an invalid command.

Transitions:
- `ST_IDLE` goes to `ST_WR_HI` or `ST_RD_HI` on a valid command, and to `ST_DONE` on an invalid block address.
- `ST_WR_HI` goes to `ST_WR_LO`, and `ST_RD_HI` goes to `ST_RD_LO`.
- `ST_WR_LO` goes back to `ST_WR_HI`, and `ST_RD_LO` back to `ST_RD_HI`, while words remain.
- `ST_WR_LO` and `ST_RD_LO` go to `ST_DONE` after word 0.
- Every state returns to `ST_IDLE` in the cycle after `cs_n` is high.

Top module: `coe_block_xfer`

## Requirements
- R1: After reset, `tx_valid` is 0, `tx_byte` is 0 and the controller waits for a command byte.
- R2: A command byte carries the direction in bit 7 (1 = read, 0 = write) and the block number in bits 4:0. Blocks 0 to 4 select word bases 0, 8, 16, 24 and 32. Any other block number makes the engine ignore the whole frame: no word is written and `tx_valid` stays 0.
- R3: On a write, the bytes after the command come in pairs of high byte then low byte. Each pair stores the word {high[7:0], low[7:2]}, and low[1:0] is discarded. The first pair goes to word base+7 and later pairs descend to base+0.
- R4: A write word is stored into every channel whose `ch_enable` bit was set when the command was accepted. All other channels keep their contents.
- R5: On a read, each byte strobe after the command yields one `tx_valid` pulse with `tx_byte` in the next cycle. Each word produces two bytes: first word[13:6], then {word[5:0], 2'b00}. Words are sent from base+7 down to base+0.
- R6: A read returns the words of the lowest-numbered channel enabled at command time. With no channel enabled, every read byte is 0.
- R7: Raising `cs_n` returns the engine to idle in the next cycle. Words whose both bytes were received stay written, and a word with only its high byte received is not written.
- R8: After the 16th data byte of a block, further byte strobes in the same frame write nothing and produce no `tx_valid`.
- R9: Byte strobes while `cs_n` is high are ignored and produce no `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Frame select, active low; high aborts the frame |
| rx_valid | input | 1 | One-cycle strobe marking a byte slot on `rx_byte` |
| rx_byte | input | 8 | Command or write data byte |
| ch_enable | input | NCH | Channel-enable mask, sampled with the command byte |
| tx_valid | output | 1 | Pulse marking a fresh read byte on `tx_byte` |
| tx_byte | output | 8 | Read data byte, high byte of each word first |

## Verification
The assertions check several rules on every cycle:
- the return to idle after `cs_n` rises;
- `tx_valid` appearing only one cycle after an accepted strobe;
- zero spare bits in every low read byte;
- a RAM write only ever closing a byte pair;
- silence in the done state and while deselected.

Other behaviour needs the bench's scenarios, because it is visible only through read-back:
- which channels a write reached and which channel a read drew from;
- the descending word order and the byte packing;
- the fate of a half-received word after an abort;
- the ignoring of invalid block numbers.

// File: rtl/coe_pkg.sv
package coe_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 14;
    localparam int SPARE_W = 2 * BYTE_W - WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_HI,
        ST_RD_LO,
        ST_DONE
    } xfer_state_t;
endpackage

// File: rtl/coe_store.sv
module coe_store #(
    parameter int NCH   = 4,
    parameter int DEPTH = 40,
    parameter int WW    = 14,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           we,
    input  logic [NCH-1:0] we_mask,
    input  logic [AW-1:0]  waddr,
    input  logic [WW-1:0]  wdata,
    input  logic [CW-1:0]  rch,
    input  logic [AW-1:0]  raddr,
    output logic [WW-1:0]  rdata
);
    logic [WW-1:0] mem [NCH][DEPTH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (we && we_mask[c])
                mem[c][waddr] <= wdata;
        end
    end

    assign rdata = mem[rch][raddr];
endmodule

// File: rtl/coe_lowest_pick.sv
module coe_lowest_pick #(
    parameter int N  = 4,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic [CW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i])
                idx = CW'(i);
        end
    end

    assign any = |mask;
endmodule

// File: rtl/coe_block_xfer.sv
module coe_block_xfer
    import coe_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int NUM_BLK   = 5,
    parameter int BLK_WORDS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rx_valid,
    input  logic [7:0]     rx_byte,
    input  logic [NCH-1:0] ch_enable,
    output logic           tx_valid,
    output logic [7:0]     tx_byte
);
    localparam int DEPTH = NUM_BLK * BLK_WORDS;
    localparam int AW    = $clog2(DEPTH);
    localparam int IW    = $clog2(BLK_WORDS);
    localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;

    xfer_state_t    state, nxt;
    logic [IW-1:0]  widx;
    logic [AW-1:0]  base_q;
    logic [NCH-1:0] mask_q;
    logic [7:0]     hi_q;

    logic           strobe;
    logic           cmd_rd;
    logic           blk_ok;
    logic [AW-1:0]  base_d;
    logic           ram_we;
    logic [AW-1:0]  addr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;
    logic [CW-1:0]  rd_ch;
    logic           rd_any;

    assign strobe = rx_valid && !cs_n;
    assign cmd_rd = rx_byte[7];
    assign blk_ok = 32'(rx_byte[4:0]) < NUM_BLK;
    assign base_d = AW'(32'(rx_byte[4:0]) * BLK_WORDS);
    assign addr   = base_q + AW'(widx);
    assign wdata  = {hi_q, rx_byte[7:SPARE_W]};
    assign ram_we = (state == ST_WR_LO) && strobe;

    coe_lowest_pick #(.N(NCH)) u_pick (
        .mask (mask_q),
        .idx  (rd_ch),
        .any  (rd_any)
    );

    coe_store #(.NCH(NCH), .DEPTH(DEPTH), .WW(WORD_W)) u_store (
        .clk     (clk),
        .we      (ram_we),
        .we_mask (mask_q),
        .waddr   (addr),
        .wdata   (wdata),
        .rch     (rd_ch),
        .raddr   (addr),
        .rdata   (rdata)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (strobe) nxt = !blk_ok ? ST_DONE : (cmd_rd ? ST_RD_HI : ST_WR_HI);
                ST_WR_HI: if (strobe) nxt = ST_WR_LO;
                ST_WR_LO: if (strobe) nxt = (widx == '0) ? ST_DONE : ST_WR_HI;
                ST_RD_HI: if (strobe) nxt = ST_RD_LO;
                ST_RD_LO: if (strobe) nxt = (widx == '0) ? ST_DONE : ST_RD_HI;
                ST_DONE:  nxt = ST_DONE;
            endcase
        end
    end

    // state register and transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            widx   <= '0;
            base_q <= '0;
            mask_q <= '0;
            hi_q   <= '0;
        end else begin
            state <= nxt;
            if (strobe) begin
                unique case (state)
                    ST_IDLE: begin
                        widx   <= IW'(BLK_WORDS - 1);
                        base_q <= base_d;
                        mask_q <= ch_enable;
                    end
                    ST_WR_HI: hi_q <= rx_byte;
                    ST_WR_LO, ST_RD_LO: widx <= widx - 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= 1'b0;
            if (strobe && state == ST_RD_HI) begin
                tx_valid <= 1'b1;
                tx_byte  <= rd_any ? rdata[WORD_W-1:WORD_W-8] : 8'h00;
            end else if (strobe && state == ST_RD_LO) begin
                tx_valid <= 1'b1;
                tx_byte  <= rd_any ? {rdata[WORD_W-9:0], {SPARE_W{1'b0}}} : 8'h00;
            end
        end
    end
endmodule

// File: rtl/coe_block_xfer_chk.sv
module coe_block_xfer_chk
    import coe_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        rx_valid,
    input logic        tx_valid,
    input logic [7:0]  tx_byte,
    input xfer_state_t state,
    input logic        ram_we
);
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> state == ST_IDLE); // R7
    AST_TX_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> $past(rx_valid && !cs_n)); // R5
    AST_TX_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && $past(state) == ST_RD_LO) |-> tx_byte[1:0] == 2'b00); // R5
    AST_WE_CLOSES_PAIR: assert property (@(posedge clk) disable iff (!rst_n) ram_we |=> state != ST_WR_LO); // R3
    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) state == ST_DONE |-> !ram_we); // R8
    AST_DONE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n) state == ST_DONE |=> !tx_valid); // R8
    AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !tx_valid); // R9
endmodule

bind coe_block_xfer coe_block_xfer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .state    (state),
    .ram_we   (ram_we)
);

// File: tb/sim_coe_block_xfer.sv
`timescale 1ns/1ps
module sim_coe_block_xfer;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           rx_valid = 1'b0;
    logic [7:0]     rx_byte = '0;
    logic [NCH-1:0] ch_enable = '0;
    logic           tx_valid;
    logic [7:0]     tx_byte;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [13:0] model [NCH][40];

    always #2.5 clk = ~clk;

    coe_block_xfer u0 (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rx_valid (rx_valid),
        .rx_byte (rx_byte), .ch_enable (ch_enable),
        .tx_valid (tx_valid), .tx_byte (tx_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hi_of(int blk, int w, int p);
        return 8'((blk * 37 + w * 11 + p * 53 + 5) & 255);
    endfunction

    function automatic logic [7:0] lo_of(int blk, int w, int p);
        return 8'((blk * 29 + w * 7 + p * 91 + 3) & 255);
    endfunction

    task automatic xfer(input logic [7:0] b, output logic v, output logic [7:0] r);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        v = tx_valid;
        r = tx_byte;
    endtask

    task automatic sel(input logic [NCH-1:0] m);
        @(negedge clk);
        ch_enable = m;
        cs_n = 1'b0;
    endtask

    task automatic desel();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    // write nw words (plus an optional lone high byte) of block blk
    task automatic wr_part(input logic [NCH-1:0] m, input int blk, input int p,
                           input int nw, input bit half, input int extra);
        logic v;
        logic [7:0] r;
        sel(m);
        xfer({3'b000, 5'(blk)}, v, r);
        for (int k = 0; k < nw; k++) begin
            int w;
            w = 7 - k;
            xfer(hi_of(blk, w, p), v, r);
            xfer(lo_of(blk, w, p), v, r);
            if (blk < 5)
                for (int c = 0; c < NCH; c++)
                    if (m[c]) model[c][blk * 8 + w] = {hi_of(blk, w, p), lo_of(blk, w, p)[7:2]};
        end
        if (half) xfer(hi_of(blk, 7 - nw, p), v, r);
        for (int e = 0; e < extra; e++) begin
            xfer(8'hA5, v, r);
            check("R8 no tx after block", 32'(v), 0);
        end
        desel();
    endtask

    // read block blk, compare against channel ch (ch < 0: all zero)
    task automatic rd_chk(input string req, input logic [NCH-1:0] m, input int blk,
                          input int ch, input int nbytes);
        logic v;
        logic [7:0] r;
        sel(m);
        xfer({3'b100, 5'(blk)}, v, r);
        for (int k = 0; k < nbytes; k++) begin
            logic [13:0] wv;
            logic [7:0] eb;
            xfer(8'h00, v, r);
            if (k >= 16) begin
                check("R8 no tx after block", 32'(v), 0);
            end else begin
                wv = (ch < 0) ? 14'h0 : model[ch][blk * 8 + 7 - k / 2];
                eb = (k % 2 == 0) ? wv[13:6] : {wv[5:0], 2'b00};
                check(req, 32'(v), 1);
                check(req, 32'(r), 32'(eb));
            end
        end
        desel();
    endtask

    initial begin
        logic v;
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 tx_byte", 32'(tx_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_valid after release", 32'(tx_valid), 0);

        // R3 R4: broadcast writes to all channels, then per-channel and two-channel overwrites
        for (int b = 0; b < 5; b++) wr_part(4'hF, b, 0, 8, 1'b0, 0);
        for (int b = 0; b < 5; b++) wr_part(NCH'(1 << (b % NCH)), b, 1, 8, 1'b0, 0);
        wr_part(4'b1010, 2, 2, 8, 1'b0, 0);

        // R5 R6: sweep every channel and block
        for (int c = 0; c < NCH; c++)
            for (int b = 0; b < 5; b++)
                rd_chk("R5/R4 read-back", NCH'(1 << c), b, c, 16);

        // R6 lowest enabled channel, and empty mask
        rd_chk("R6 lowest channel", 4'b0110, 2, 1, 16);
        rd_chk("R6 lowest channel", 4'b1100, 2, 2, 16);
        rd_chk("R6 empty mask reads zero", 4'b0000, 0, -1, 16);
        wr_part(4'b0000, 4, 7, 8, 1'b0, 0);
        for (int c = 0; c < NCH; c++) rd_chk("R4 empty mask writes nothing", NCH'(1 << c), 4, c, 16);

        // R2 invalid block numbers ignored
        wr_part(4'hF, 5, 9, 8, 1'b0, 0);
        wr_part(4'hF, 31, 9, 8, 1'b0, 0);
        for (int b = 0; b < 5; b++) rd_chk("R2 invalid write ignored", 4'b0001, b, 0, 16);
        sel(4'hF);
        xfer(8'h85, v, r);
        for (int k = 0; k < 4; k++) begin
            xfer(8'h00, v, r);
            check("R2 invalid read silent", 32'(v), 0);
        end
        desel();

        // R7 abort mid-word: two whole words plus one lone high byte
        wr_part(4'b0001, 1, 5, 2, 1'b1, 0);
        rd_chk("R7 abort keeps whole words only", 4'b0001, 1, 0, 16);
        // R7 abort a read, then a fresh command works
        rd_chk("R7 read aborted", 4'b0001, 3, 0, 3);
        rd_chk("R7 read after abort", 4'b0001, 3, 0, 16);

        // R8 surplus bytes after a block
        wr_part(4'b0100, 0, 6, 8, 1'b0, 3);
        rd_chk("R8 surplus write ignored", 4'b0100, 0, 2, 19);

        // R9 strobes while deselected
        @(negedge clk);
        ch_enable = 4'b0001;
        for (int k = 0; k < 3; k++) begin
            xfer(8'h80, v, r);
            check("R9 deselected strobe silent", 32'(v), 0);
        end
        rd_chk("R9 state intact", 4'b0001, 0, 0, 16);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule